// File: doc/BRIEF.md
# Serial/Parallel Delay Length Loader

This block produces the 11-bit length code that sets a variable delay line. The code comes from one of two sources, chosen by a source-select input. With the select high, the code is read straight from eleven code pins. With the select low, the three lowest code pins form a small serial port instead: bit 0 carries data, bit 1 is a shift clock and bit 2 is a latch strobe. The remaining eight pins are not used in that mode.

The serial shift clock and strobe may run with no phase relation to the main clock. Shifted bits build up in a shift register in the shift-clock domain. A strobe edge copies them into a holding register and flips a toggle. The main clock domain synchronises the toggle and captures the held word in one piece, so it never sees a partly updated code. The selected code leaves the block through a register on the main clock. A code of zero stands for the shortest delay (31 samples), and each unit of the code adds one sample.

Top module: `delay_code_loader`

## Requirements
- R1: While `src_par` is 1, `len_code` equals the value `code_pins` had at the previous rising edge of `clk`. Bit 0 of `code_pins` is the least significant bit.
- R2: While `src_par` is 0, `code_pins[0]` is serial data, `code_pins[1]` is the shift clock and `code_pins[2]` is the latch strobe. `code_pins[10:3]` have no effect on `len_code`.
- R3: On each rising edge of the shift clock, the serial data bit enters bit 0 of the shift register and the older bits move one place up. The most significant bit is sent first, so after 11 edges the first bit sent is in bit 10. When more than 11 bits are sent, only the last 11 are kept.
- R4: A rising edge of the latch strobe copies the shift register into the holding register. Shift edges without a strobe leave `len_code` unchanged.
- R5: The word captured at a strobe edge appears on `len_code` as one complete 11-bit value no later than 5 `clk` cycles after the strobe edge, provided `src_par` is 0.
- R6: While `src_par` is 0, `len_code` shows the most recently latched serial word. This also holds right after a switch from parallel mode, when no new serial load has taken place.
- R7: While `rst_n` is 0, `len_code` is 0. The reset also clears the shift register and the holding register, so a strobe with no shifts after reset produces 0.
- R8: While `src_par` is 1, activity on `code_pins[1]` and `code_pins[2]` neither shifts nor latches the serial registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main sample clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised to `clk` inside the block |
| src_par | input | 1 | Source select: 1 = parallel pins, 0 = three-wire serial port |
| code_pins | input | 11 | Parallel code; in serial mode bit 0 = data, bit 1 = shift clock, bit 2 = latch strobe |
| len_code | output | 11 | Registered length code (delay = 31 + code) |

## Verification
Two functions can overlap in time: a strobe arriving from the asynchronous serial domain, and the main-clock output register that selects its source. The bench sends serial words with unused pins carrying garbage. It switches between parallel and serial mode around loads and fires strobes immediately after reset. After each strobe it waits a fixed, worst-case number of main clock cycles, then requires the whole expected word. It then checks that more shift edges without a strobe, or strobe-pin activity in parallel mode, leave the word untouched.

// File: rtl/dll_pkg.sv
package dll_pkg;
  localparam int unsigned CODE_W_DEF = 11;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic {
    SRC_SERIAL   = 1'b0,
    SRC_PARALLEL = 1'b1
  } src_e;
endpackage

// File: rtl/dll_rst_sync.sv
module dll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dll_shifter.sv
module dll_shifter #(
  parameter int unsigned W = 11
) (
  input  logic         sck,
  input  logic         rst_n,
  input  logic         sdi,
  output logic [W-1:0] shift_q
);
  logic [W-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[W-2:0], sdi};
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end
endmodule

// File: rtl/dll_hold.sv
module dll_hold #(
  parameter int unsigned W = 11
) (
  input  logic         stb,
  input  logic         rst_n,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] hold_q,
  output logic         flip_q
);
  logic [W-1:0] hold_d;
  logic         flip_d;

  always_comb begin
    hold_d = word_in;
    flip_d = ~flip_q;
  end

  always_ff @(posedge stb or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      flip_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      flip_q <= flip_d;
    end
  end
endmodule

// File: rtl/dll_cdc.sv
module dll_cdc #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flip_in,
  input  logic [W-1:0] word_in,
  output logic         load_pulse,
  output logic [W-1:0] word_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              seen_q;
  logic              seen_d;
  logic [W-1:0]      word_d;
  logic              word_en;

  always_comb begin
    sync_d     = {sync_q[STAGES-2:0], flip_in};
    seen_d     = sync_q[STAGES-1];
    load_pulse = sync_q[STAGES-1] ^ seen_q;
    word_en    = load_pulse;
    word_d     = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end
endmodule

// File: rtl/delay_code_loader.sv
module delay_code_loader
  import dll_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_par,
  input  logic [CODE_W-1:0] code_pins,
  output logic [CODE_W-1:0] len_code
);
  localparam int unsigned SDI_BIT = 0;
  localparam int unsigned SCK_BIT = 1;
  localparam int unsigned STB_BIT = 2;

  src_e              src_sel;
  logic              rst_n_s;
  logic              ser_sdi;
  logic              ser_sck;
  logic              ser_stb;
  logic [CODE_W-1:0] shift_q;
  logic [CODE_W-1:0] hold_q;
  logic              flip_q;
  logic              load_pulse;
  logic [CODE_W-1:0] ser_code;
  logic [CODE_W-1:0] code_d;

  assign src_sel = src_e'(src_par);

  // serial port pins are only live while serial source is selected
  always_comb begin
    ser_sdi = code_pins[SDI_BIT];
    ser_sck = code_pins[SCK_BIT] & (src_sel == SRC_SERIAL);
    ser_stb = code_pins[STB_BIT] & (src_sel == SRC_SERIAL);
  end

  dll_rst_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dll_shifter #(.W(CODE_W)) u_shifter (
    .sck     (ser_sck),
    .rst_n   (rst_n),
    .sdi     (ser_sdi),
    .shift_q (shift_q)
  );

  dll_hold #(.W(CODE_W)) u_hold (
    .stb     (ser_stb),
    .rst_n   (rst_n),
    .word_in (shift_q),
    .hold_q  (hold_q),
    .flip_q  (flip_q)
  );

  dll_cdc #(.W(CODE_W), .STAGES(SYNC_N)) u_cdc (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .flip_in    (flip_q),
    .word_in    (hold_q),
    .load_pulse (load_pulse),
    .word_q     (ser_code)
  );

  always_comb begin
    code_d = (src_sel == SRC_PARALLEL) ? code_pins : ser_code;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) len_code <= '0;
    else          len_code <= code_d;
  end
endmodule

// File: rtl/delay_code_loader_chk.sv
module delay_code_loader_chk #(
  parameter int unsigned CODE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_n_s,
  input logic              src_par,
  input logic [CODE_W-1:0] code_pins,
  input logic [CODE_W-1:0] len_code,
  input logic [CODE_W-1:0] ser_code,
  input logic              load_pulse
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  assert_par_follow_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed && $past(src_par)) |-> (len_code == $past(code_pins)));

  assert_ser_select_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed && !$past(src_par)) |-> (len_code == $past(ser_code)));

  assert_word_stable_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed && !$past(load_pulse)) |-> $stable(ser_code));

  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    load_pulse |=> !load_pulse);

  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_n |-> (len_code == '0));
endmodule

bind delay_code_loader delay_code_loader_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_n_s    (rst_n_s),
  .src_par    (src_par),
  .code_pins  (code_pins),
  .len_code   (len_code),
  .ser_code   (ser_code),
  .load_pulse (load_pulse)
);

// File: tb/delay_code_loader_bench.sv
`timescale 1ns/1ps
module delay_code_loader_bench;
  localparam int W = 11;
  localparam int MASK = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         src_par;
  logic [W-1:0] code_pins;
  logic [W-1:0] len_code;

  int checks;
  int fails;
  bit done;

  delay_code_loader u_delay_code_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_par   (src_par),
    .code_pins (code_pins),
    .len_code  (len_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // sends n bits MSB first, with junk on the unused pins (R2)
  task automatic ser_shift(input logic [15:0] bits, input int n, input logic [7:0] junk);
    for (int i = n - 1; i >= 0; i--) begin
      code_pins[0] = bits[i];
      code_pins[10:3] = junk ^ 8'(i * 29);
      #30;
      code_pins[1] = 1'b1;
      #30;
      code_pins[1] = 1'b0;
    end
  endtask

  task automatic ser_latch();
    #30;
    code_pins[2] = 1'b1;
    #30;
    code_pins[2] = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_serial();
    @(negedge clk);
    code_pins = '0;
    #1;
    src_par = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    done = 1'b0;
    rst_n = 1'b0;
    src_par = 1'b1;
    code_pins = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset state", len_code, '0);
    code_pins = 11'h5A5;
    @(negedge clk);
    chk("R7 code held at zero in reset", len_code, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 exhaustive parallel sweep; pins 1 and 2 toggle throughout (R8)
    for (int c = 0; c <= MASK; c++) begin
      code_pins = W'(c);
      @(negedge clk);
      chk("R1 parallel follow", len_code, W'(c));
    end

    // R7 serial registers cleared by reset: strobe with no shifts gives 0
    go_serial();
    chk("R6 serial selected after reset", len_code, '0);
    ser_latch();
    chk("R7 latch after reset", len_code, '0);

    // R3/R5 serial sweep
    for (int i = 0; i < 256; i++) begin
      logic [W-1:0] v;
      v = W'((i * 37 + 5) & MASK);
      ser_shift(16'(v), W, 8'(i));
      ser_latch();
      chk("R3 R5 serial load", len_code, v);
    end
    for (int b = 0; b < W; b++) begin
      ser_shift(16'(1 << b), W, 8'hC3);
      ser_latch();
      chk("R3 one-hot weight", len_code, W'(1 << b));
    end
    ser_shift(16'h07FF, W, 8'hFF);
    ser_latch();
    chk("R3 all ones", len_code, 11'h7FF);

    // R3 extra leading bits fall out
    ser_shift(16'hB2C9, 14, 8'h5A);
    ser_latch();
    chk("R3 excess bits dropped", len_code, W'(16'hB2C9 & MASK));

    // R4 shifting without strobe leaves output unchanged
    ser_shift(16'h0F3C, W, 8'h11);
    ser_latch();
    chk("R4 base word", len_code, 11'h73C);
    ser_shift(16'h0015, 5, 8'h22);
    repeat (6) @(negedge clk);
    chk("R4 no strobe no change", len_code, 11'h73C);
    ser_latch();
    chk("R4 strobe after partial shift", len_code, W'(((11'h73C << 5) | 11'h15) & MASK));

    // R6/R8: parallel activity then back to serial
    @(negedge clk);
    src_par = 1'b1;
    for (int c = 0; c < 64; c++) begin
      code_pins = W'(c * 3 + 1);
      @(negedge clk);
      chk("R1 parallel after serial", len_code, W'(c * 3 + 1));
    end
    go_serial();
    chk("R6 last serial word restored", len_code, W'(((11'h73C << 5) | 11'h15) & MASK));
    ser_latch();
    chk("R8 no shift during parallel mode", len_code, W'(((11'h73C << 5) | 11'h15) & MASK));

    // R2 upper pins ignored while idle in serial mode
    code_pins[10:3] = 8'hA7;
    repeat (3) @(negedge clk);
    chk("R2 upper pins ignored", len_code, W'(((11'h73C << 5) | 11'h15) & MASK));
    code_pins[10:3] = 8'h00;

    // R7 reset mid-operation clears everything
    rst_n = 1'b0;
    #1;
    @(negedge clk);
    chk("R7 reset clears output", len_code, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ser_latch();
    chk("R7 serial registers cleared", len_code, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule